// File: doc/BRIEF.md
# Vector Element Stride Permuter

This unit reorders the elements held in a group of two, three or four consecutive 64-bit vector registers. It is placed between a load/store datapath and the vector register file. It has two directions. In the spreading direction (deinterleave), a packed run of elements taken from memory is distributed so that successive elements land in successive registers of the group. In the gathering direction (interleave), the registers are merged back into one packed run ahead of a structured store, which undoes the spread.

The permutation is a stride scatter or gather. Both the register count and the element width (1, 2, 4 or 8 bytes) control it, so it is not a fixed bit shuffle. Every legal combination is wired as a separate constant routing network, and the settings select one of them. The result is captured in an output register one cycle after a valid input. The register file and the memory access itself are outside the block.

Top module: `ilv_unit`

## Requirements
- R1: The data layout is fixed. Register r of the group occupies `data[64r+63:64r]`. Element j of a register with element width W bits occupies bits `[jW+W-1:jW]` of that register, so lower-numbered elements sit in the low 32-bit half. `in_esz` codes 0/1/2/3 select 1/2/4/8-byte elements. `in_cnt` codes 0/1/2 select 2/3/4 registers.
- R2: With `in_mode`=0 (deinterleave), packed input element k (counted from bit 0 across the group) is written to register (k mod n) at position (k div n), where n is the register count.
- R3: With `in_mode`=1 (interleave), position p of input register r is written to packed output element p·n + r.
- R4: For input data that is zero above bit 64n, interleaving the deinterleaved result with the same settings returns the original data exactly.
- R5: Output registers with an index at or above n are zero. Input bits at or above 64n have no effect on the output.
- R6: The reserved count code 3 produces an all-zero result.
- R7: A result appears on `out_data` one clock after `in_vld` is high. `out_vld` equals `in_vld` delayed by one clock.
- R8: While `in_vld` is low, `out_data` holds its last value.
- R9: A synchronous active-high `rst` clears `out_vld` and `out_data` to zero.
- R10: With 8-byte elements and two registers, both modes pass the low 128 bits through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input operation valid |
| in_mode | input | 1 | 0 = deinterleave, 1 = interleave |
| in_esz | input | 2 | Element size code (1/2/4/8 bytes) |
| in_cnt | input | 2 | Register count code (2/3/4, 3 reserved) |
| in_data | input | 256 | Source register group |
| out_vld | output | 1 | Result valid |
| out_data | output | 256 | Permuted register group |

## Verification
Several properties are checked on every cycle by assertions. These are the one-cycle valid pipeline, data holding while idle, zeroed upper registers for a two-register group, the all-zero reserved count, and pass-through for 8-byte elements in two registers. The element routing for every combination of width, count and mode can only be shown by the bench's scenarios. So can the round-trip inverse and the fact that source bits above the group are ignored. The bench compares each scenario against its own element-loop model.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic {
    MODE_SPREAD = 1'b0,
    MODE_GATHER = 1'b1
  } ilv_mode_e;

  localparam int ESZ_W      = 2;
  localparam int CNT_W      = 2;
  localparam int NUM_SIZES  = 4;

endpackage

// File: rtl/ilv_perm.sv
module ilv_perm #(
  parameter int ELEM_B = 1,
  parameter int NREGS  = 2,
  parameter int REG_W  = 64,
  parameter int DATA_W = 256
) (
  input  logic [NREGS*REG_W-1:0] din,
  output logic [DATA_W-1:0]      spread,
  output logic [DATA_W-1:0]      gather
);
  localparam int EW    = ELEM_B * 8;
  localparam int PER   = REG_W / EW;
  localparam int TOT   = NREGS * PER;
  localparam int USE_W = NREGS * REG_W;

  // Packed element k <-> register (k % NREGS), slot (k / NREGS)
  for (genvar k = 0; k < TOT; k++) begin : g_elem
    localparam int R   = k % NREGS;
    localparam int P   = k / NREGS;
    localparam int RPI = R * PER + P;
    assign spread[RPI*EW +: EW] = din[k*EW +: EW];
    assign gather[k*EW +: EW]   = din[RPI*EW +: EW];
  end

  if (USE_W < DATA_W) begin : g_tail
    assign spread[DATA_W-1:USE_W] = '0;
    assign gather[DATA_W-1:USE_W] = '0;
  end

endmodule

// File: rtl/ilv_select.sv
module ilv_select
  import ilv_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int NCNT   = 3
) (
  input  ilv_mode_e                                mode,
  input  logic [ESZ_W-1:0]                         esz,
  input  logic [CNT_W-1:0]                         cnt,
  input  logic [NUM_SIZES*NCNT-1:0][DATA_W-1:0]    spread_all,
  input  logic [NUM_SIZES*NCNT-1:0][DATA_W-1:0]    gather_all,
  output logic [DATA_W-1:0]                        result
);
  localparam int NV    = NUM_SIZES * NCNT;
  localparam int IDX_W = $clog2(NV) + 1;

  logic [IDX_W-1:0] idx;

  always_comb begin
    idx    = IDX_W'(esz) * IDX_W'(NCNT) + IDX_W'(cnt);
    result = '0;
    if (int'(cnt) < NCNT && int'(idx) < NV) begin
      result = (mode == MODE_GATHER) ? gather_all[idx] : spread_all[idx];
    end
  end

endmodule

// File: rtl/ilv_unit.sv
module ilv_unit
  import ilv_pkg::*;
#(
  parameter int REG_W    = 64,
  parameter int MIN_REGS = 2,
  parameter int MAX_REGS = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_vld,
  input  logic                      in_mode,
  input  logic [1:0]                in_esz,
  input  logic [1:0]                in_cnt,
  input  logic [MAX_REGS*REG_W-1:0] in_data,
  output logic                      out_vld,
  output logic [MAX_REGS*REG_W-1:0] out_data
);
  localparam int DATA_W = MAX_REGS * REG_W;
  localparam int NCNT   = MAX_REGS - MIN_REGS + 1;
  localparam int NV     = NUM_SIZES * NCNT;

  logic [NV-1:0][DATA_W-1:0] spread_all;
  logic [NV-1:0][DATA_W-1:0] gather_all;
  logic [DATA_W-1:0]         sel_data;

  for (genvar gs = 0; gs < NUM_SIZES; gs++) begin : g_size
    for (genvar gc = 0; gc < NCNT; gc++) begin : g_cnt
      localparam int NR = MIN_REGS + gc;
      ilv_perm #(
        .ELEM_B (1 << gs),
        .NREGS  (NR),
        .REG_W  (REG_W),
        .DATA_W (DATA_W)
      ) u_perm (
        .din    (in_data[NR*REG_W-1:0]),
        .spread (spread_all[gs*NCNT+gc]),
        .gather (gather_all[gs*NCNT+gc])
      );
    end
  end

  ilv_select #(
    .DATA_W (DATA_W),
    .NCNT   (NCNT)
  ) u_sel (
    .mode       (ilv_mode_e'(in_mode)),
    .esz        (in_esz),
    .cnt        (in_cnt),
    .spread_all (spread_all),
    .gather_all (gather_all),
    .result     (sel_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_data <= sel_data;
    end
  end

  // R7
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);
  // R7
  vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);
  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(out_data));
  // R5
  tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_cnt == 2'd0) |=> (out_data[DATA_W-1:MIN_REGS*REG_W] == '0));
  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_cnt == 2'd3) |=> (out_data == '0));
  // R10
  wide_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_cnt == 2'd0 && in_esz == 2'd3)
      |=> (out_data[2*REG_W-1:0] == $past(in_data[2*REG_W-1:0])));

endmodule

// File: tb/tb_ilv_unit.sv
module tb_ilv_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 256;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_vld;
  logic          in_mode;
  logic [1:0]    in_esz;
  logic [1:0]    in_cnt;
  logic [DW-1:0] in_data;
  logic          out_vld;
  logic [DW-1:0] out_data;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilv_unit dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_mode(in_mode),
    .in_esz(in_esz), .in_cnt(in_cnt), .in_data(in_data),
    .out_vld(out_vld), .out_data(out_data)
  );

  // {mode, esz, cnt, seed}
  localparam logic [12:0] VEC [12] = '{
    {1'b0, 2'd0, 2'd0, 8'h11}, {1'b0, 2'd0, 2'd1, 8'h22},
    {1'b0, 2'd0, 2'd2, 8'h33}, {1'b0, 2'd1, 2'd1, 8'h44},
    {1'b0, 2'd2, 2'd2, 8'h55}, {1'b0, 2'd3, 2'd1, 8'h66},
    {1'b1, 2'd0, 2'd0, 8'h77}, {1'b1, 2'd0, 2'd1, 8'h88},
    {1'b1, 2'd1, 2'd2, 8'h99}, {1'b1, 2'd2, 2'd1, 8'hAA},
    {1'b1, 2'd3, 2'd2, 8'hBB}, {1'b1, 2'd1, 2'd0, 8'hCC}
  };

  function automatic logic [DW-1:0] mk_data(input logic [7:0] seed, input int nbytes);
    logic [DW-1:0] d = '0;
    for (int i = 0; i < nbytes; i++) d[i*8 +: 8] = seed + 8'(i * 37);
    return d;
  endfunction

  // Reference: loop over destination register r and slot p
  function automatic logic [DW-1:0] ref_perm(input logic mode, input logic [1:0] esz,
                                             input logic [1:0] cnt, input logic [DW-1:0] din);
    logic [DW-1:0] o = '0;
    int n, eb, per;
    if (cnt == 2'd3) return o;
    n = int'(cnt) + 2;
    eb = 1 << esz;
    per = 8 / eb;
    for (int r = 0; r < n; r++)
      for (int p = 0; p < per; p++)
        for (int b = 0; b < eb; b++) begin
          if (!mode) o[((r*per+p)*eb+b)*8 +: 8] = din[((p*n+r)*eb+b)*8 +: 8];
          else       o[((p*n+r)*eb+b)*8 +: 8] = din[((r*per+p)*eb+b)*8 +: 8];
        end
    return o;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic run(input logic m, input logic [1:0] e, input logic [1:0] c,
                     input logic [DW-1:0] d, output logic [DW-1:0] res);
    @(negedge clk);
    in_mode = m; in_esz = e; in_cnt = c; in_data = d; in_vld = 1'b1;
    @(negedge clk);
    res = out_data;
    check("R7 valid", {255'd0, out_vld}, {255'd0, 1'b1});
    in_vld = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d, r1, r2, base;
    rst = 1'b1; in_vld = 1'b1; in_mode = 1'b0; in_esz = 2'd0; in_cnt = 2'd2;
    in_data = {DW{1'b1}};
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset data", out_data, '0);
    check("R9 reset valid", {255'd0, out_vld}, '0);
    in_vld = 1'b0;
    rst = 1'b0;

    // R2 R3 table walk
    foreach (VEC[i]) begin
      int nb = (int'(VEC[i][9:8]) + 2) * 8;
      d = mk_data(VEC[i][7:0], nb);
      run(VEC[i][12], VEC[i][11:10], VEC[i][9:8], d, r1);
      check(VEC[i][12] ? "R3 gather" : "R2 spread", r1,
            ref_perm(VEC[i][12], VEC[i][11:10], VEC[i][9:8], d));
    end

    // R1 concrete: 2-byte elems, 2 regs, spread: reg1 slot0 = element 1
    d = '0; d[31:16] = 16'hBEEF;
    run(1'b0, 2'd1, 2'd0, d, r1);
    check("R1 layout", r1, {128'd0, 48'd0, 16'hBEEF, 64'd0});

    // R4 round trip
    for (int c = 0; c < 3; c++) begin
      d = mk_data(8'h5A + 8'(c), (c + 2) * 8);
      run(1'b0, 2'(c), 2'(c), d, r1);
      run(1'b1, 2'(c), 2'(c), r1, r2);
      check("R4 round trip", r2, d);
    end

    // R5 upper input bits ignored, upper output zero
    base = mk_data(8'h3C, 16);
    run(1'b0, 2'd0, 2'd0, base, r1);
    d = base; d[DW-1:128] = {128{1'b1}};
    run(1'b0, 2'd0, 2'd0, d, r2);
    check("R5 ignore upper", r2, r1);
    check("R5 zero upper", {128'd0, r2[DW-1:128]}, '0);

    // R6 reserved count
    run(1'b1, 2'd2, 2'd3, mk_data(8'h01, 32), r1);
    check("R6 reserved", r1, '0);

    // R10 8-byte, two registers
    d = mk_data(8'hE1, 16);
    run(1'b0, 2'd3, 2'd0, d, r1);
    check("R10 spread pass", r1, d);
    run(1'b1, 2'd3, 2'd0, d, r1);
    check("R10 gather pass", r1, d);

    // R8 hold while idle
    run(1'b0, 2'd2, 2'd2, mk_data(8'h70, 32), r1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_data = mk_data(8'(k * 9), 32); in_mode = ~in_mode;
    end
    @(negedge clk);
    check("R8 hold", out_data, r1);
    check("R7 idle valid", {255'd0, out_vld}, '0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule